// File: doc/BRIEF.md
# Interrupt Latency History Buffer

This block keeps a short trace of the interrupts a controller has serviced, so that the time each one waited can be measured in hardware. Beside the trace it holds one timestamp per interrupt source. Whenever a source appears in the controller's mask of newly pending requests, its timestamp is loaded with the current cycle count. When the controller takes an interrupt, the block writes one trace record: the source number, the cycle of the take, and the stored raise time for that source. It also counts every take.

A read port lists the trace from newest to oldest. A request names a position, where 0 is the newest record, and one cycle later the port returns the source, the take cycle, the latency (take minus raise), and the distance in cycles back to the record listed just before it. The port also raises an end marker when the position holds no record. A reader walks positions upward from zero and stops at the first end marker. The cycle count comes in on a port, so the block can share a timebase with the rest of the chip.

Top module: `irq_latency_log`

## Requirements
- R1: Each take writes one record holding the taken source number, the `now_cycle` value at the take, and the raise stamp held for that source. A read returns the source on `rd_id` and the take cycle on `rd_taken`.
- R2: Takes fill slots in a ring. The write slot starts at 0, advances by one on each take, and returns to 0 after slot DEPTH-1. Once more than DEPTH takes have occurred, only the newest DEPTH records can be read.
- R3: On every clock where bit j of `pend_new` is 1, the stamp of source j is loaded with `now_cycle`. Several bits may load in the same cycle. A take in the same cycle as a reload of its own source records the stamp from before that reload.
- R4: Reset clears every record, every stamp, the write slot and the take counter to zero.
- R5: A read at position p returns the record written p takes before the newest one. `rd_valid` is 1 exactly in the cycle after a cycle with `rd_req` at 1, and the read fields update at that edge.
- R6: `rd_end` is 1 when the selected record has a take cycle of zero, or when p is DEPTH or more. When `rd_end` is 1, `rd_id`, `rd_taken`, `rd_latency`, `rd_gap` and `rd_gap_ok` are all zero.
- R7: `rd_latency` equals the take cycle minus the raise cycle, modulo 2^TS_W.
- R8: For p greater than 0, `rd_gap_ok` is 1 and `rd_gap` equals the take cycle at position p-1 minus the take cycle at position p, modulo 2^TS_W. For p equal to 0, both are zero.
- R9: `taken_total` increases by one on every take, wraps modulo 2^CNT_W, and holds its value otherwise.
- R10: If a take writes the slot that a read selects in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_cycle | input | TS_W | Current cycle count used for all timestamps |
| pend_new | input | NUM_SRC | Sources that became pending this cycle |
| take_en | input | 1 | The controller takes an interrupt this cycle |
| take_id | input | ID_W | Source number being taken |
| rd_req | input | 1 | Read request |
| rd_pos | input | IDX_W+1 | Read position, 0 = newest |
| rd_valid | output | 1 | Read result valid |
| rd_end | output | 1 | Selected position holds no record |
| rd_id | output | ID_W | Source number of the record |
| rd_taken | output | TS_W | Take cycle of the record |
| rd_latency | output | TS_W | Take cycle minus raise cycle |
| rd_gap | output | TS_W | Distance to the record listed just before |
| rd_gap_ok | output | 1 | `rd_gap` is meaningful |
| taken_total | output | CNT_W | Number of takes, wrapping |

## Verification
Assertions check properties that hold on every cycle. They check the step of the write slot with its wrap, the contents written into a slot on each take, and the loading of every raise stamp. They also check the counter step, the one-cycle valid timing of the read port, and that an end marker or position 0 carries zeroed fields. Only the bench's scenarios can show the newest-first ordering across a full ring, the latency and gap arithmetic for a given history, and the old-stamp rule when a take coincides with a reload. The same holds for the old-contents rule when a read and a write meet on one slot, and for the clearing by reset in the middle of a run.

// File: rtl/irq_hist_pkg.sv
package irq_hist_pkg;

   // true when v is a nonzero power of two
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // index width needed to address v items, never below one bit
   function automatic int unsigned idx_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/irq_raise_stamp.sv
module irq_raise_stamp
   import irq_hist_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned TS_W    = 32,
   parameter int unsigned ID_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TS_W-1:0]    now_cycle,
   input  logic [NUM_SRC-1:0] pend_new,
   input  logic [ID_W-1:0]    sel_id,
   output logic [TS_W-1:0]    sel_stamp
);

   localparam bit FULL_MAP = (NUM_SRC == (1 << ID_W));

   logic [TS_W-1:0] stamp_q [NUM_SRC];

   for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stamp_q[j] <= '0;
         end else if (pend_new[j]) begin
            stamp_q[j] <= now_cycle;
         end
      end

      // R3
      stamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pend_new[j] |=> stamp_q[j] == $past(now_cycle));
   end

   // the lookup sees the value held before this edge's reload
   if (FULL_MAP) begin : g_sel_full
      assign sel_stamp = stamp_q[sel_id];
   end else begin : g_sel_guard
      always_comb begin
         sel_stamp = '0;
         for (int k = 0; k < NUM_SRC; k++) begin
            if (sel_id == ID_W'(k)) sel_stamp = stamp_q[k];
         end
      end
   end

endmodule

// File: rtl/irq_hist_ring.sv
module irq_hist_ring
   import irq_hist_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ID_W  = 3,
   parameter int unsigned TS_W  = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ID_W-1:0]  wr_id,
   input  logic [TS_W-1:0]  wr_taken,
   input  logic [TS_W-1:0]  wr_raised,
   output logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [ID_W-1:0]  ra_id,
   output logic [TS_W-1:0]  ra_taken,
   output logic [TS_W-1:0]  ra_raised,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [TS_W-1:0]  rb_taken
);

   localparam bit              POW2    = is_pow2(DEPTH);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic [ID_W-1:0]  id_q     [DEPTH];
   logic [TS_W-1:0]  taken_q  [DEPTH];
   logic [TS_W-1:0]  raised_q [DEPTH];
   logic [IDX_W-1:0] wr_idx_q;
   logic [IDX_W-1:0] wr_idx_nx;

   // next write slot: free wrap for a power of two, compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign wr_idx_nx = wr_idx_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_idx_nx = (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx_q <= '0;
      end else if (wr_en) begin
         wr_idx_q <= wr_idx_nx;
      end
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_q[s]     <= '0;
            taken_q[s]  <= '0;
            raised_q[s] <= '0;
         end else if (wr_en && (wr_idx_q == IDX_W'(s))) begin
            id_q[s]     <= wr_id;
            taken_q[s]  <= wr_taken;
            raised_q[s] <= wr_raised;
         end
      end
   end

   assign wr_idx    = wr_idx_q;
   assign ra_id     = id_q[ra_idx];
   assign ra_taken  = taken_q[ra_idx];
   assign ra_raised = raised_q[ra_idx];
   assign rb_taken  = taken_q[rb_idx];

   // R2
   wr_idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> int'(wr_idx_q) == (int'($past(wr_idx_q)) + 1) % int'(DEPTH));

   // R2
   wr_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> wr_idx_q == $past(wr_idx_q));

   // R1
   slot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> taken_q[$past(wr_idx_q)] == $past(wr_taken)
                && id_q[$past(wr_idx_q)] == $past(wr_id));

endmodule

// File: rtl/irq_hist_reader.sv
module irq_hist_reader
   import irq_hist_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ID_W  = 3,
   parameter int unsigned TS_W  = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned POS_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             rd_req,
   input  logic [POS_W-1:0] rd_pos,
   output logic [IDX_W-1:0] ra_idx,
   input  logic [ID_W-1:0]  ra_id,
   input  logic [TS_W-1:0]  ra_taken,
   input  logic [TS_W-1:0]  ra_raised,
   output logic [IDX_W-1:0] rb_idx,
   input  logic [TS_W-1:0]  rb_taken,
   output logic             rd_valid,
   output logic             rd_end,
   output logic [ID_W-1:0]  rd_id,
   output logic [TS_W-1:0]  rd_taken,
   output logic [TS_W-1:0]  rd_latency,
   output logic [TS_W-1:0]  rd_gap,
   output logic             rd_gap_ok
);

   localparam bit              POW2  = is_pow2(DEPTH);
   localparam int unsigned     SUM_W = IDX_W + 2;
   localparam logic [SUM_W-1:0] D_S  = SUM_W'(DEPTH);

   logic             in_range;
   logic [POS_W-1:0] pos_c;
   logic [SUM_W-1:0] self_raw;
   logic [SUM_W-1:0] prev_raw;
   logic             is_end;
   logic             has_prev;

   always_comb begin
      in_range = (rd_pos < POS_W'(DEPTH));
      pos_c    = in_range ? rd_pos : '0;
      // newest sits one behind the write slot; older ones further back
      self_raw = SUM_W'(wr_idx) + D_S - SUM_W'(1) - SUM_W'(pos_c);
      prev_raw = SUM_W'(wr_idx) + D_S - SUM_W'(pos_c);
   end

   if (POW2) begin : g_mod_pow2
      assign ra_idx = self_raw[IDX_W-1:0];
      assign rb_idx = prev_raw[IDX_W-1:0];
   end else begin : g_mod_sub
      logic [SUM_W-1:0] self_m;
      logic [SUM_W-1:0] prev_m;
      always_comb begin
         self_m = (self_raw >= D_S) ? self_raw - D_S : self_raw;
         prev_m = (prev_raw >= D_S) ? prev_raw - D_S : prev_raw;
      end
      assign ra_idx = self_m[IDX_W-1:0];
      assign rb_idx = prev_m[IDX_W-1:0];
   end

   assign is_end   = !in_range || (ra_taken == '0);
   assign has_prev = (pos_c != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_end     <= 1'b0;
         rd_id      <= '0;
         rd_taken   <= '0;
         rd_latency <= '0;
         rd_gap     <= '0;
         rd_gap_ok  <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_end <= is_end;
            if (is_end) begin
               rd_id      <= '0;
               rd_taken   <= '0;
               rd_latency <= '0;
               rd_gap     <= '0;
               rd_gap_ok  <= 1'b0;
            end else begin
               rd_id      <= ra_id;
               rd_taken   <= ra_taken;
               rd_latency <= ra_taken - ra_raised;
               rd_gap     <= has_prev ? (rb_taken - ra_taken) : '0;
               rd_gap_ok  <= has_prev;
            end
         end
      end
   end

   // R5
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   // R5
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   // R6
   end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_end) |-> (rd_taken == '0 && rd_id == '0 && !rd_gap_ok));

   // R8
   first_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_pos == '0) |=> (!rd_gap_ok && rd_gap == '0));

endmodule

// File: rtl/irq_latency_log.sv
module irq_latency_log
   import irq_hist_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned TS_W    = 32,
   parameter int unsigned CNT_W   = 16,
   localparam int unsigned ID_W   = idx_bits(NUM_SRC),
   localparam int unsigned IDX_W  = idx_bits(DEPTH),
   localparam int unsigned POS_W  = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TS_W-1:0]    now_cycle,
   input  logic [NUM_SRC-1:0] pend_new,
   input  logic               take_en,
   input  logic [ID_W-1:0]    take_id,
   input  logic               rd_req,
   input  logic [POS_W-1:0]   rd_pos,
   output logic               rd_valid,
   output logic               rd_end,
   output logic [ID_W-1:0]    rd_id,
   output logic [TS_W-1:0]    rd_taken,
   output logic [TS_W-1:0]    rd_latency,
   output logic [TS_W-1:0]    rd_gap,
   output logic               rd_gap_ok,
   output logic [CNT_W-1:0]   taken_total
);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_latency_log: NUM_SRC must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("irq_latency_log: DEPTH must be at least 2");
   end
   if (TS_W < 2 || TS_W > 64) begin : g_bad_ts
      $error("irq_latency_log: TS_W must lie in 2..64");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("irq_latency_log: CNT_W must be at least 1");
   end

   logic [TS_W-1:0]  raise_of_take;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] ra_idx;
   logic [IDX_W-1:0] rb_idx;
   logic [ID_W-1:0]  ra_id;
   logic [TS_W-1:0]  ra_taken;
   logic [TS_W-1:0]  ra_raised;
   logic [TS_W-1:0]  rb_taken;
   logic [CNT_W-1:0] total_q;

   irq_raise_stamp #(
      .NUM_SRC (NUM_SRC),
      .TS_W    (TS_W),
      .ID_W    (ID_W)
   ) u_stamp (
      .clk       (clk),
      .rst_n     (rst_n),
      .now_cycle (now_cycle),
      .pend_new  (pend_new),
      .sel_id    (take_id),
      .sel_stamp (raise_of_take)
   );

   irq_hist_ring #(
      .DEPTH (DEPTH),
      .ID_W  (ID_W),
      .TS_W  (TS_W),
      .IDX_W (IDX_W)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (take_en),
      .wr_id     (take_id),
      .wr_taken  (now_cycle),
      .wr_raised (raise_of_take),
      .wr_idx    (wr_idx),
      .ra_idx    (ra_idx),
      .ra_id     (ra_id),
      .ra_taken  (ra_taken),
      .ra_raised (ra_raised),
      .rb_idx    (rb_idx),
      .rb_taken  (rb_taken)
   );

   irq_hist_reader #(
      .DEPTH (DEPTH),
      .ID_W  (ID_W),
      .TS_W  (TS_W),
      .IDX_W (IDX_W),
      .POS_W (POS_W)
   ) u_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_idx     (wr_idx),
      .rd_req     (rd_req),
      .rd_pos     (rd_pos),
      .ra_idx     (ra_idx),
      .ra_id      (ra_id),
      .ra_taken   (ra_taken),
      .ra_raised  (ra_raised),
      .rb_idx     (rb_idx),
      .rb_taken   (rb_taken),
      .rd_valid   (rd_valid),
      .rd_end     (rd_end),
      .rd_id      (rd_id),
      .rd_taken   (rd_taken),
      .rd_latency (rd_latency),
      .rd_gap     (rd_gap),
      .rd_gap_ok  (rd_gap_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_q <= '0;
      end else if (take_en) begin
         total_q <= total_q + 1'b1;
      end
   end

   assign taken_total = total_q;

   // R9
   total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |=> taken_total == CNT_W'($past(taken_total) + 1'b1));

   // R9
   total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_en |=> $stable(taken_total));

endmodule

// File: tb/irq_latency_log_bench.sv
`timescale 1ns/1ps
module irq_latency_log_bench;

   localparam int B_SRC   = 8;
   localparam int B_DEPTH = 12;
   localparam int B_TS    = 32;
   localparam int B_CNT   = 4;
   localparam int B_ID    = 3;
   localparam int B_POS   = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [B_TS-1:0]   now_cycle = '0;
   logic [B_SRC-1:0]  pend_new = '0;
   logic              take_en = 1'b0;
   logic [B_ID-1:0]   take_id = '0;
   logic              rd_req = 1'b0;
   logic [B_POS-1:0]  rd_pos = '0;
   logic              rd_valid;
   logic              rd_end;
   logic [B_ID-1:0]   rd_id;
   logic [B_TS-1:0]   rd_taken;
   logic [B_TS-1:0]   rd_latency;
   logic [B_TS-1:0]   rd_gap;
   logic              rd_gap_ok;
   logic [B_CNT-1:0]  taken_total;

   irq_latency_log #(
      .NUM_SRC (B_SRC),
      .DEPTH   (B_DEPTH),
      .TS_W    (B_TS),
      .CNT_W   (B_CNT)
   ) u_irq_latency_log (
      .clk         (clk),
      .rst_n       (rst_n),
      .now_cycle   (now_cycle),
      .pend_new    (pend_new),
      .take_en     (take_en),
      .take_id     (take_id),
      .rd_req      (rd_req),
      .rd_pos      (rd_pos),
      .rd_valid    (rd_valid),
      .rd_end      (rd_end),
      .rd_id       (rd_id),
      .rd_taken    (rd_taken),
      .rd_latency  (rd_latency),
      .rd_gap      (rd_gap),
      .rd_gap_ok   (rd_gap_ok),
      .taken_total (taken_total)
   );

   always #2.5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int unsigned cyc = 0;

   // reference model, built from the requirements
   int          m_id    [B_DEPTH];
   logic [31:0] m_tk    [B_DEPTH];
   logic [31:0] m_rs    [B_DEPTH];
   logic [31:0] m_stamp [B_SRC];
   int          m_wr;
   int          m_total;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < B_DEPTH; k++) begin
         m_id[k] = 0; m_tk[k] = '0; m_rs[k] = '0;
      end
      for (int k = 0; k < B_SRC; k++) m_stamp[k] = '0;
      m_wr = 0;
      m_total = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pend_new = '0; take_en = 1'b0; rd_req = 1'b0;
      repeat (3) @(negedge clk);
      model_clear();
      rst_n = 1'b1;
   endtask

   // one clock: drive at negedge, expect from pre-edge model, check at next negedge
   task automatic step(input string note, input logic [7:0] pnd, input bit tk,
                       input int tid, input bit rq, input int pos);
      logic [31:0] e_tk, e_lat, e_gap;
      int          e_id;
      bit          e_end, e_gok;
      int          s, p;
      cyc++;
      now_cycle = cyc;
      pend_new  = pnd;
      take_en   = tk;
      take_id   = tid[B_ID-1:0];
      rd_req    = rq;
      rd_pos    = pos[B_POS-1:0];
      e_id = 0; e_tk = '0; e_lat = '0; e_gap = '0; e_end = 1'b1; e_gok = 1'b0;
      if (pos < B_DEPTH) begin
         s = (m_wr + B_DEPTH - 1 - pos) % B_DEPTH;
         p = (m_wr + B_DEPTH - pos) % B_DEPTH;
         if (m_tk[s] != 0) begin
            e_end = 1'b0;
            e_id  = m_id[s];
            e_tk  = m_tk[s];
            e_lat = m_tk[s] - m_rs[s];
            e_gok = (pos > 0);
            e_gap = (pos > 0) ? m_tk[p] - m_tk[s] : '0;
         end
      end
      @(posedge clk);
      if (tk) begin
         m_id[m_wr] = tid;
         m_tk[m_wr] = cyc;
         m_rs[m_wr] = m_stamp[tid];
         m_wr       = (m_wr + 1) % B_DEPTH;
         m_total    = (m_total + 1) % (1 << B_CNT);
      end
      for (int j = 0; j < B_SRC; j++) if (pnd[j]) m_stamp[j] = cyc;
      @(negedge clk);
      chk({"R5 valid ", note}, rd_valid, rq);
      chk({"R9 total ", note}, taken_total, m_total);
      if (rq) begin
         chk({"R6 end ", note}, rd_end, e_end);
         chk({"R1 id ", note}, rd_id, e_id);
         chk({"R1 taken ", note}, rd_taken, e_tk);
         chk({"R7 latency ", note}, rd_latency, e_lat);
         chk({"R8 gap ", note}, rd_gap, e_gap);
         chk({"R8 gap_ok ", note}, rd_gap_ok, e_gok);
      end
      pend_new = '0; take_en = 1'b0; rd_req = 1'b0;
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_clear();
      do_reset();

      // R4: cleared state after reset, nothing listed
      chk("R4 total after reset", taken_total, 0);
      chk("R4 valid after reset", rd_valid, 0);
      step("R4 empty read", 8'h00, 0, 0, 1, 0);

      // R3 R7: source 3 raised, taken four cycles later
      step("R3 raise src3", 8'h08, 0, 0, 0, 0);
      step("idle", 8'h00, 0, 0, 0, 0);
      step("idle", 8'h00, 0, 0, 0, 0);
      step("idle", 8'h00, 0, 0, 0, 0);
      step("R1 take src3", 8'h00, 1, 3, 0, 0);
      step("R7 read newest", 8'h00, 0, 0, 1, 0);
      chk("R7 latency directed", rd_latency, 4);
      chk("R1 id directed", rd_id, 3);

      // R3: take and reload of the same source in one cycle keeps the old stamp
      step("R3 raise src5", 8'h20, 0, 0, 0, 0);
      step("idle", 8'h00, 0, 0, 0, 0);
      step("R3 take with reload", 8'h20, 1, 5, 0, 0);
      step("R3 read old stamp", 8'h00, 0, 0, 1, 0);
      chk("R3 latency old stamp", rd_latency, 2);

      // R8: gap to the previous listed record
      step("R8 read second", 8'h00, 0, 0, 1, 1);
      chk("R8 gap directed", rd_gap, 4);
      // R6: third position empty, position beyond depth ends
      step("R6 read past fill", 8'h00, 0, 0, 1, 2);
      chk("R6 end directed", rd_end, 1);
      step("R6 read beyond depth", 8'h00, 0, 0, 1, B_DEPTH);

      // R3: several sources stamped together, then taken
      step("R3 multi raise", 8'hC3, 0, 0, 0, 0);
      step("R3 take src7", 8'h00, 1, 7, 0, 0);
      step("R3 take src0", 8'h00, 1, 0, 1, 0);
      step("R3 read src0", 8'h00, 0, 0, 1, 0);

      // R2 R5 R7 R8 R9: random traffic, fills and wraps the ring many times
      for (int n = 0; n < 600; n++) begin
         logic [7:0] pr;
         pr = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
         step("R2 random", pr, ($urandom % 5) < 2, int'($urandom % B_SRC),
              ($urandom % 4) != 0, int'($urandom % (B_DEPTH + 2)));
      end

      // R2: oldest visible record is exactly DEPTH-1 takes back
      for (int k = 0; k < B_DEPTH + 3; k++) step("R2 fill", 8'h00, 1, k % B_SRC, 0, 0);
      for (int k = 0; k < B_DEPTH; k++) step("R2 walk", 8'h00, 0, 0, 1, k);

      // R10: read selects the slot being overwritten in the same cycle
      step("R10 collision", 8'h00, 1, 6, 1, B_DEPTH - 1);
      step("R10 after write", 8'h00, 0, 0, 1, 0);
      chk("R10 newest is src6", rd_id, 6);

      // R4: reset in the middle of a run clears everything
      do_reset();
      chk("R4 total after mid reset", taken_total, 0);
      step("R4 empty after mid reset", 8'h00, 0, 0, 1, 0);
      chk("R4 end after mid reset", rd_end, 1);
      step("R4 take after mid reset", 8'h00, 1, 2, 1, 0);
      step("R4 stamp cleared", 8'h00, 0, 0, 1, 0);

      summary();
      $finish;
   end

endmodule